// File: doc/BRIEF.md
# ADC Capture and Sample Memory Fill Controller

This controller runs one acquisition. It drives an external parallel ADC and stores its results, one by one, into a sample memory that has one location per address. A pulse on `start_i` begins a run from address zero. A new run overwrites whatever the previous run stored.

Each sample follows a fixed schedule. The ADC convert strobe is held low for the conversion wait. There is then one cycle in which the ADC result is captured into a holding register. The RAM write strobe is then held low while that register drives the memory data bus at the current address. The address then advances and the next conversion begins straight away.

Once the last address has been written, the controller parks with both strobes released and `done_o` high. It stays there until the next start pulse or reset. With the defaults, a sample takes 16 clocks, so the sampling rate is the clock frequency divided by 16, and a run covers 32768 locations.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While `rst_ni` is low, and until the first start pulse, `adc_wr_no` and `ram_we_no` are 1, `done_o` is 0 and `ram_addr_o` is 0.
- R2: After a clock edge that samples `start_i` high, `adc_wr_no` is low for exactly CONV_CNT (default 10) consecutive cycles.
- R3: A single capture cycle follows the conversion wait, with both strobes high. The `adc_data_i` value present at the end of that cycle appears on `ram_data_o` during the write that follows.
- R4: `ram_we_no` is low for exactly WR_CNT (default 5) consecutive cycles right after the capture cycle. `ram_addr_o` and `ram_data_o` do not change during those cycles.
- R5: Consecutive falling edges of `adc_wr_no` within one run are exactly CONV_CNT+1+WR_CNT (default 16) clocks apart.
- R6: The first sample of a run is stored at address 0. Each later sample is stored at the previous address plus one.
- R7: After the write to address 2^ADDR_W-1, `done_o` goes high and both strobes stay high. All three hold until a start pulse or reset.
- R8: `adc_wr_no` and `ram_we_no` are never low in the same cycle.
- R9: A start pulse during a run, or after completion, restarts at once. The address returns to 0, `done_o` clears and a new conversion wait of CONV_CNT cycles begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin (or restart) an acquisition run |
| adc_data_i | input | DATA_W | Parallel ADC result |
| adc_wr_no | output | 1 | ADC convert strobe, active low |
| ram_we_no | output | 1 | RAM write strobe, active low |
| ram_data_o | output | DATA_W | Captured sample driven to RAM |
| ram_addr_o | output | ADDR_W | RAM address of the current sample |
| done_o | output | 1 | Memory full, run finished |

## Verification
The bench targets the moment of capture. It changes the ADC data every cycle, so a design that captured one cycle early or late would store a neighbouring value. It measures strobe widths and the spacing of conversions, which catches an off-by-one terminal count as a 15- or 17-clock period. It runs a short address space to completion and waits past the end, which exposes a design that wraps to address 0 and keeps writing, or that drops `done_o`. Restarts arrive mid-conversion and after completion, and an asynchronous reset lands mid-run; a design that kept its old address or stretched a conversion would show it at once.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CONV  = 3'd1,
    ST_LATCH = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_e;
endpackage

// File: rtl/adc_cap_tc_counter.sv
// Modulo counter; held at zero while disabled, terminal count flagged only when enabled.
module adc_cap_tc_counter #(
  parameter int unsigned MOD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tc_o
);
  localparam int unsigned CW = (MOD > 1) ? $clog2(MOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);

  logic [CW-1:0] cnt_q;

  assign tc_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || !en_i)   cnt_q <= '0;
    else if (cnt_q == LAST)    cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_cap_addr_counter.sv
module adc_cap_addr_counter #(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;

  assign addr_o = addr_q;
  assign last_o = &addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (step_i) addr_q <= addr_q + 1'b1;
  end
endmodule

// File: rtl/adc_cap_sample_reg.sv
module adc_cap_sample_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/adc_cap_fsm.sv
module adc_cap_fsm
  import adc_cap_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic conv_tc_i,
  input  logic wr_tc_i,
  input  logic addr_last_i,
  output logic conv_en_o,
  output logic wr_en_o,
  output logic latch_o,
  output logic addr_clr_o,
  output logic addr_step_o,
  output logic adc_wr_no,
  output logic ram_we_no,
  output logic done_o
);
  cap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (start_i) begin
      state_d = ST_CONV;
    end else begin
      unique case (state_q)
        ST_CONV:  if (conv_tc_i) state_d = ST_LATCH;
        ST_LATCH: state_d = ST_WRITE;
        ST_WRITE: if (wr_tc_i) state_d = addr_last_i ? ST_DONE : ST_CONV;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign conv_en_o   = (state_q == ST_CONV);
  assign wr_en_o     = (state_q == ST_WRITE);
  assign latch_o     = (state_q == ST_LATCH);
  assign addr_clr_o  = start_i;
  assign addr_step_o = (state_q == ST_WRITE) && wr_tc_i && !addr_last_i && !start_i;
  assign adc_wr_no   = (state_q != ST_CONV);
  assign ram_we_no   = (state_q != ST_WRITE);
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned CONV_CNT = 10,
  parameter int unsigned WR_CNT   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              adc_wr_no,
  output logic              ram_we_no,
  output logic [DATA_W-1:0] ram_data_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              done_o
);
  logic conv_en, wr_en, latch_en, addr_clr, addr_step;
  logic conv_tc, wr_tc, addr_last;

  adc_cap_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .conv_tc_i   (conv_tc),
    .wr_tc_i     (wr_tc),
    .addr_last_i (addr_last),
    .conv_en_o   (conv_en),
    .wr_en_o     (wr_en),
    .latch_o     (latch_en),
    .addr_clr_o  (addr_clr),
    .addr_step_o (addr_step),
    .adc_wr_no   (adc_wr_no),
    .ram_we_no   (ram_we_no),
    .done_o      (done_o)
  );

  adc_cap_tc_counter #(.MOD(CONV_CNT)) u_conv_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (conv_en),
    .tc_o   (conv_tc)
  );

  adc_cap_tc_counter #(.MOD(WR_CNT)) u_wr_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .en_i   (wr_en),
    .tc_o   (wr_tc)
  );

  adc_cap_addr_counter #(.ADDR_W(ADDR_W)) u_addr_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (addr_clr),
    .step_i (addr_step),
    .addr_o (ram_addr_o),
    .last_o (addr_last)
  );

  adc_cap_sample_reg #(.DATA_W(DATA_W)) u_sample (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (latch_en && !start_i),
    .d_i    (adc_data_i),
    .q_o    (ram_data_o)
  );
endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned CONV_CNT = 10,
  parameter int unsigned WR_CNT   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              adc_wr_no,
  input logic              ram_we_no,
  input logic [DATA_W-1:0] ram_data_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              done_o
);
  int unsigned conv_run_q, wr_run_q;

  // Length of the low stretch so far, restarted by a start pulse.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_run_q <= 0;
      wr_run_q   <= 0;
    end else begin
      conv_run_q <= (start_i || adc_wr_no) ? 0 : conv_run_q + 1;
      wr_run_q   <= (start_i || ram_we_no) ? 0 : wr_run_q + 1;
    end
  end

  assert_strobes_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!adc_wr_no && !ram_we_no));

  assert_conv_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_wr_no |-> conv_run_q < CONV_CNT);

  assert_write_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_no |-> wr_run_q < WR_CNT);

  assert_write_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_we_no && $past(!ram_we_no)) |-> ($stable(ram_addr_o) && $stable(ram_data_o)));

  assert_capture_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_we_no) |-> $past(adc_wr_no && ram_we_no));

  assert_addr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ram_addr_o) |-> (ram_addr_o == '0 || ram_addr_o == ADDR_W'($past(ram_addr_o) + 1'b1)));

  assert_done_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (adc_wr_no && ram_we_no && (&ram_addr_o)));

  assert_done_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  assert_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!done_o && !adc_wr_no && ram_addr_o == '0));
endmodule

bind adc_capture_ctrl adc_capture_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CONV_CNT(CONV_CNT), .WR_CNT(WR_CNT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .adc_wr_no  (adc_wr_no),
  .ram_we_no  (ram_we_no),
  .ram_data_o (ram_data_o),
  .ram_addr_o (ram_addr_o),
  .done_o     (done_o)
);

// File: tb/adc_capture_ctrl_bench.sv
module adc_capture_ctrl_bench;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int CONV = 10;
  localparam int WR = 5;
  localparam int PERIOD = CONV + 1 + WR;
  localparam int LAST_ADDR = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [DW-1:0] adc_data_i = '0;
  logic adc_wr_no, ram_we_no, done_o;
  logic [DW-1:0] ram_data_o;
  logic [AW-1:0] ram_addr_o;

  always #10 clk = ~clk;

  adc_capture_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CONV_CNT(CONV), .WR_CNT(WR)) u_adc_capture_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .adc_data_i(adc_data_i),
    .adc_wr_no(adc_wr_no), .ram_we_no(ram_we_no), .ram_data_o(ram_data_o),
    .ram_addr_o(ram_addr_o), .done_o(done_o)
  );

  int checks = 0, errors = 0;

  // Behavioural reference: run flag, phase within the sample period, address, held sample.
  bit m_act, m_done;
  int m_phase, m_addr, m_samp;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_act = 0; m_done = 0; m_phase = 0; m_addr = 0; m_samp = 0;
    end else if (start_i) begin
      m_act = 1; m_done = 0; m_phase = 0; m_addr = 0;
    end else if (m_act) begin
      if (m_phase == CONV) m_samp = int'(adc_data_i);
      if (m_phase == PERIOD - 1) begin
        m_phase = 0;
        if (m_addr == LAST_ADDR) begin m_act = 0; m_done = 1; end
        else m_addr = m_addr + 1;
      end else m_phase = m_phase + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  int cyc = 0, last_fall = -1;
  bit prev_adc = 1'b1, restart_pending = 1'b0;

  task automatic do_checks();
    bit exp_adc, exp_we;
    exp_adc = !(m_act && m_phase < CONV);
    exp_we  = !(m_act && m_phase > CONV);
    if (!rst_ni) begin
      chk("R1 adc strobe", int'(adc_wr_no), 1);
      chk("R1 ram strobe", int'(ram_we_no), 1);
      chk("R1 done", int'(done_o), 0);
      chk("R1 addr", int'(ram_addr_o), 0);
    end else begin
      chk("R2 adc strobe", int'(adc_wr_no), int'(exp_adc));
      chk("R4 ram strobe", int'(ram_we_no), int'(exp_we));
      chk(restart_pending ? "R9 addr" : "R6 addr", int'(ram_addr_o), m_addr);
      chk("R7 done", int'(done_o), int'(m_done));
      chk("R8 exclusive", int'(!adc_wr_no && !ram_we_no), 0);
      if (!exp_we) chk("R3 data", int'(ram_data_o), m_samp);
      if (prev_adc && !adc_wr_no) begin
        if (last_fall >= 0) chk("R5 period", cyc - last_fall, PERIOD);
        last_fall = cyc;
      end
    end
    restart_pending = 1'b0;
    prev_adc = adc_wr_no;
  endtask

  task automatic tick(input bit st);
    @(negedge clk);
    cyc++;
    do_checks();
    if (st) begin
      last_fall = -1;
      restart_pending = 1'b1;
    end
    start_i = st;
    adc_data_i = DW'(cyc * 37 + 11);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b0);
  endtask

  initial begin
    run(3);                       // R1 under reset
    rst_ni = 1'b1;
    run(5);                       // R1 idle after reset
    tick(1'b1);                   // first run
    run(PERIOD * (LAST_ADDR + 1) + 20);  // complete, then R7 hold
    tick(1'b1);                   // R9 restart after completion
    run(PERIOD * 2 + 4);          // mid-conversion of third sample
    tick(1'b1);                   // R9 restart mid-run
    run(PERIOD * (LAST_ADDR + 1) + 10);
    tick(1'b1);
    run(PERIOD + 13);             // inside a write
    @(negedge clk);
    rst_ni = 1'b0;                // asynchronous reset mid-run
    run(2);
    rst_ni = 1'b1;
    run(6);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule